// File: doc/BRIEF.md
# Gear-Shifting PI Loop Filter

This block is the digital loop filter of a fully digital PLL. On every reference-clock update it takes one signed phase-error word and produces one unsigned oscillator tuning word. The word is the sum of a proportional term, an integral term and a programmable centre value.

The filter holds two coefficient sets, each a pair of power-of-two gains given as left-shift amounts. The wide set is used while the loop acquires. The narrow set is used once the loop tracks. The controller has two named states. In ACQUIRE the wide set is active. In TRACK the narrow set is active.

Two transitions lead from ACQUIRE to TRACK:
- LOCK_SHIFT is taken when the lock detector sees enough consecutive small errors.
- TIMEOUT_SHIFT is taken when a programmed number of updates has elapsed.

TRACK has only one transition, TRACK_HOLD, which stays in TRACK until reset. On the shift, the proportional term of that update is folded into the accumulator, so the tuning word does not step when the gains change.

Top module: `gear_pi_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to ACQUIRE, clears the accumulator and the lock counter, deasserts `locked` and `tracking`, and loads `tune_word` with `center_word`.
- R2: State and outputs change only at an edge where `upd_valid` is high. The new `tune_word` is visible after that same edge.
- R3: The proportional term is `phase_err * 2^kp`. `kp` is `acq_kp_sh` in ACQUIRE and `trk_kp_sh` in TRACK.
- R4: The integral accumulator adds `phase_err * 2^ki` on each update. `ki` is `acq_ki_sh` in ACQUIRE and `trk_ki_sh` in TRACK. The output uses the accumulator value after this addition.
- R5: The accumulator is a signed 24-bit value. It clamps at +8388607 and -8388608 and never wraps.
- R6: `tune_word` = `center_word` + proportional + accumulator, clamped to the range 0 to 65535.
- R7: An update is in window when |`phase_err`| < `lock_thresh` (strictly less). `locked` rises at the update that completes `lock_need` consecutive in-window updates. Any out-of-window update clears both the count and `locked`.
- R8: LOCK_SHIFT: in ACQUIRE, the update that raises `locked` moves the state to TRACK. That update still uses the acquisition gains.
- R9: TIMEOUT_SHIFT: in ACQUIRE with `shift_timeout` nonzero, the `shift_timeout`-th update moves the state to TRACK. A value of 0 disables the timer.
- R10: On a shift update, that update's proportional term is added into the accumulator. An update with zero error right after the shift therefore leaves `tune_word` unchanged.
- R11: TRACK_HOLD: once in TRACK, the state stays there until reset, even when `locked` falls. `tracking` is high exactly in TRACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | One reference update per high cycle |
| phase_err | input | 12 | Signed phase error |
| acq_kp_sh | input | 3 | Acquisition proportional shift |
| acq_ki_sh | input | 3 | Acquisition integral shift |
| trk_kp_sh | input | 3 | Tracking proportional shift |
| trk_ki_sh | input | 3 | Tracking integral shift |
| center_word | input | 16 | Centre tuning offset, unsigned |
| lock_thresh | input | 12 | Lock window bound, unsigned |
| lock_need | input | 8 | Consecutive in-window updates needed for lock |
| shift_timeout | input | 16 | Update count that forces the shift; 0 disables it |
| tune_word | output | 16 | Oscillator tuning word, unsigned |
| locked | output | 1 | Lock flag |
| tracking | output | 1 | High in TRACK |

## Verification
Three short error sequences (positive, zero, negative) separate the proportional part, which disappears on a zero error, from the integral part, which persists.

Long runs at the largest error of each sign drive the accumulator into both clamps. A wrapping accumulator would flip the output to the opposite rail.

A lock sequence mixes in-window errors with an error exactly at the threshold and a negative error. This shows that the count is consecutive, that the threshold comparison is strict, and that the magnitude is used.

A zero error right after each kind of shift shows whether the proportional term was folded into the accumulator. A nonzero error after the shift shows that the tracking gains took over.

// File: rtl/gpf_pkg.sv
`timescale 1ns/1ps
package gpf_pkg;
    typedef enum logic [0:0] {
        GEAR_ACQ = 1'b0,
        GEAR_TRK = 1'b1
    } gear_e;
endpackage

// File: rtl/gpf_gain_shift.sv
`timescale 1ns/1ps
// Power-of-two gain: sign-extend the error, then shift it left.
module gpf_gain_shift #(
    parameter int EW  = 12,
    parameter int SHW = 3,
    parameter int OW  = EW + (1 << SHW) - 1
) (
    input  logic signed [EW-1:0]  err,
    input  logic        [SHW-1:0] sh,
    output logic signed [OW-1:0]  term
);
    logic signed [OW-1:0] ext;

    assign ext  = OW'(err);
    assign term = ext <<< sh;
endmodule

// File: rtl/gpf_lock_detect.sv
`timescale 1ns/1ps
// Counts consecutive small-error updates.
module gpf_lock_detect #(
    parameter int EW = 12,
    parameter int NW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_valid,
    input  logic signed [EW-1:0] err,
    input  logic        [EW-1:0] thresh,
    input  logic        [NW-1:0] need,
    output logic                 lock_now,
    output logic                 locked_q
);
    logic [EW:0] ext;
    logic [EW:0] mag;
    logic        in_win;
    logic [NW-1:0] cnt_q;
    logic [NW:0]   cnt_p1;
    logic          reach;

    assign ext    = {err[EW-1], err};
    assign mag    = ext[EW] ? (~ext + 1'b1) : ext;
    assign in_win = mag < {1'b0, thresh};
    assign cnt_p1 = {1'b0, cnt_q} + 1'b1;
    assign reach  = cnt_p1 >= {1'b0, need};
    assign lock_now = upd_valid && in_win && reach;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
        end else if (upd_valid) begin
            if (in_win) begin
                cnt_q    <= (&cnt_q) ? cnt_q : cnt_p1[NW-1:0];
                locked_q <= locked_q | reach;
            end else begin
                cnt_q    <= '0;
                locked_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/gpf_integrator.sv
`timescale 1ns/1ps
// Saturating accumulator with an optional fold-in term on a gear shift.
module gpf_integrator #(
    parameter int AW = 24,
    parameter int PW = 19
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_valid,
    input  logic signed [PW-1:0] inc,
    input  logic                 fold,
    input  logic signed [PW-1:0] fold_term,
    output logic signed [AW-1:0] acc_next,
    output logic signed [AW-1:0] acc_q
);
    localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};

    function automatic logic signed [AW-1:0] sat_add(
        input logic signed [AW-1:0] a,
        input logic signed [PW-1:0] b
    );
        logic signed [AW:0] s;
        s = $signed({a[AW-1], a}) + $signed((AW+1)'(b));
        if (s[AW] != s[AW-1]) return s[AW] ? AMIN : AMAX;
        return s[AW-1:0];
    endfunction

    logic signed [AW-1:0] acc_fold;

    assign acc_next = sat_add(acc_q, inc);
    assign acc_fold = sat_add(acc_next, fold_term);

    always_ff @(posedge clk) begin
        if (rst)            acc_q <= '0;
        else if (upd_valid) acc_q <= fold ? acc_fold : acc_next;
    end
endmodule

// File: rtl/gear_pi_filter.sv
`timescale 1ns/1ps
module gear_pi_filter
    import gpf_pkg::*;
#(
    parameter int EW  = 12,
    parameter int CW  = 16,
    parameter int AW  = 24,
    parameter int SHW = 3,
    parameter int NW  = 8,
    parameter int TW  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_valid,
    input  logic signed [EW-1:0] phase_err,
    input  logic [SHW-1:0]       acq_kp_sh,
    input  logic [SHW-1:0]       acq_ki_sh,
    input  logic [SHW-1:0]       trk_kp_sh,
    input  logic [SHW-1:0]       trk_ki_sh,
    input  logic [CW-1:0]        center_word,
    input  logic [EW-1:0]        lock_thresh,
    input  logic [NW-1:0]        lock_need,
    input  logic [TW-1:0]        shift_timeout,
    output logic [CW-1:0]        tune_word,
    output logic                 locked,
    output logic                 tracking
);
    localparam int PW = EW + (1 << SHW) - 1;
    localparam int SW = AW + 2;
    localparam logic signed [SW-1:0] OUT_MAX = $signed({{(SW-CW){1'b0}}, {CW{1'b1}}});

    gear_e gear_q, gear_d;
    logic  shift_now;
    logic  lock_now;
    logic  tmr_hit;
    logic [TW-1:0] tmr_q;
    logic [TW:0]   tmr_p1;
    logic [SHW-1:0] kp_sel, ki_sel;
    logic signed [PW-1:0] p_term, i_term;
    logic signed [AW-1:0] acc_next, acc_q;
    logic signed [SW-1:0] total;
    logic [CW-1:0] tune_d, tune_q;

    // Coefficient set follows the gear.
    assign kp_sel = (gear_q == GEAR_TRK) ? trk_kp_sh : acq_kp_sh;
    assign ki_sel = (gear_q == GEAR_TRK) ? trk_ki_sh : acq_ki_sh;

    gpf_gain_shift #(.EW(EW), .SHW(SHW), .OW(PW)) u_pgain (
        .err (phase_err), .sh (kp_sel), .term (p_term)
    );
    gpf_gain_shift #(.EW(EW), .SHW(SHW), .OW(PW)) u_igain (
        .err (phase_err), .sh (ki_sel), .term (i_term)
    );

    gpf_lock_detect #(.EW(EW), .NW(NW)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .err       (phase_err),
        .thresh    (lock_thresh),
        .need      (lock_need),
        .lock_now  (lock_now),
        .locked_q  (locked)
    );

    gpf_integrator #(.AW(AW), .PW(PW)) u_integ (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .inc       (i_term),
        .fold      (shift_now),
        .fold_term (p_term),
        .acc_next  (acc_next),
        .acc_q     (acc_q)
    );

    // Acquisition timer
    assign tmr_p1  = {1'b0, tmr_q} + 1'b1;
    assign tmr_hit = (shift_timeout != '0) && (tmr_p1 >= {1'b0, shift_timeout});

    always_ff @(posedge clk) begin
        if (rst)
            tmr_q <= '0;
        else if (upd_valid && gear_q == GEAR_ACQ)
            tmr_q <= (&tmr_q) ? tmr_q : tmr_p1[TW-1:0];
    end

    // Next-state logic: LOCK_SHIFT, TIMEOUT_SHIFT, TRACK_HOLD
    always_comb begin
        gear_d = gear_q;
        unique case (gear_q)
            GEAR_ACQ: if (upd_valid && (lock_now || tmr_hit)) gear_d = GEAR_TRK;
            GEAR_TRK: gear_d = GEAR_TRK;
        endcase
    end

    assign shift_now = (gear_q == GEAR_ACQ) && (gear_d == GEAR_TRK);

    // State register
    always_ff @(posedge clk) begin
        if (rst) gear_q <= GEAR_ACQ;
        else     gear_q <= gear_d;
    end

    // Output word: centre + P + I, clamped
    always_comb begin
        total = $signed({{(SW-CW){1'b0}}, center_word}) + SW'(p_term) + SW'(acc_next);
        if (total < 0)            tune_d = '0;
        else if (total > OUT_MAX) tune_d = '1;
        else                      tune_d = total[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)            tune_q <= center_word;
        else if (upd_valid) tune_q <= tune_d;
    end

    assign tune_word = tune_q;
    assign tracking  = (gear_q == GEAR_TRK);
endmodule

// File: rtl/gpf_checker.sv
`timescale 1ns/1ps
module gpf_checker
    import gpf_pkg::*;
#(
    parameter int EW = 12,
    parameter int CW = 16,
    parameter int AW = 24,
    parameter int PW = 19
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 upd_valid,
    input logic signed [EW-1:0] phase_err,
    input logic [EW-1:0]        lock_thresh,
    input logic [CW-1:0]        center_word,
    input logic [CW-1:0]        tune_word,
    input logic                 locked,
    input logic                 tracking,
    input gear_e                gear_q,
    input logic                 shift_now,
    input logic signed [PW-1:0] i_term,
    input logic signed [AW-1:0] acc_q
);
    localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};

    logic [EW:0] chk_mag;
    assign chk_mag = phase_err[EW-1] ? (EW+1)'(-$signed({phase_err[EW-1], phase_err}))
                                     : {1'b0, phase_err};

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!locked && !tracking && tune_word == $past(center_word)));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(tune_word) && $stable(locked) && $stable(acc_q));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !shift_now && acc_q == AMAX && i_term >= 0) |=> acc_q == AMAX);

    assert_lock_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && chk_mag >= {1'b0, lock_thresh}) |=> !locked);

    assert_lock_gear_R8: assert property (@(posedge clk) disable iff (rst)
        locked |-> tracking);

    assert_track_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (gear_q == GEAR_TRK) |=> (gear_q == GEAR_TRK) && tracking);
endmodule

bind gear_pi_filter gpf_checker #(.EW(EW), .CW(CW), .AW(AW), .PW(PW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .upd_valid   (upd_valid),
    .phase_err   (phase_err),
    .lock_thresh (lock_thresh),
    .center_word (center_word),
    .tune_word   (tune_word),
    .locked      (locked),
    .tracking    (tracking),
    .gear_q      (gear_q),
    .shift_now   (shift_now),
    .i_term      (i_term),
    .acc_q       (acc_q)
);

// File: tb/gear_pi_filter_tb.sv
`timescale 1ns/1ps
module gear_pi_filter_tb_top;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               upd_valid = 1'b0;
    logic signed [11:0] phase_err = '0;
    logic [2:0]         acq_kp_sh = '0, acq_ki_sh = '0, trk_kp_sh = '0, trk_ki_sh = '0;
    logic [15:0]        center_word = '0;
    logic [11:0]        lock_thresh = '0;
    logic [7:0]         lock_need = 8'd1;
    logic [15:0]        shift_timeout = '0;
    logic [15:0]        tune_word;
    logic               locked, tracking;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gear_pi_filter dut_i (
        .clk (clk), .rst (rst), .upd_valid (upd_valid), .phase_err (phase_err),
        .acq_kp_sh (acq_kp_sh), .acq_ki_sh (acq_ki_sh),
        .trk_kp_sh (trk_kp_sh), .trk_ki_sh (trk_ki_sh),
        .center_word (center_word), .lock_thresh (lock_thresh),
        .lock_need (lock_need), .shift_timeout (shift_timeout),
        .tune_word (tune_word), .locked (locked), .tracking (tracking)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic update(input int e);
        @(negedge clk);
        phase_err = 12'(e);
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic config_set(input int akp, input int aki, input int tkp, input int tki,
                              input int ctr, input int thr, input int need, input int tmo);
        acq_kp_sh = 3'(akp); acq_ki_sh = 3'(aki);
        trk_kp_sh = 3'(tkp); trk_ki_sh = 3'(tki);
        center_word = 16'(ctr); lock_thresh = 12'(thr);
        lock_need = 8'(need); shift_timeout = 16'(tmo);
    endtask

    task automatic t_reset_state();
        config_set(4, 1, 1, 0, 1000, 0, 1, 0);
        do_reset();
        chk("R1 tune", tune_word, 1000);
        chk("R1 locked", locked, 0);
        chk("R1 tracking", tracking, 0);
    endtask

    task automatic t_pi_paths();
        config_set(4, 1, 1, 0, 1000, 0, 1, 0);
        do_reset();
        update(3);  chk("R3 R4 R6 err=3", tune_word, 1054);
        update(0);  chk("R4 integral kept", tune_word, 1006);
        update(-2); chk("R3 R4 negative", tune_word, 970);
        chk("R9 timer disabled", tracking, 0);
    endtask

    task automatic t_idle_hold();
        phase_err = 12'sd500;
        repeat (5) @(negedge clk);
        chk("R2 no update without valid", tune_word, 970);
    endtask

    task automatic t_out_clamp();
        config_set(4, 0, 1, 0, 65500, 0, 1, 0);
        do_reset();
        update(100);  chk("R6 upper clamp", tune_word, 65535);
        update(0);    chk("R6 upper clamp zero err", tune_word, 65535);
        update(-100); chk("R6 back in range", tune_word, 63900);
        config_set(4, 0, 1, 0, 10, 0, 1, 0);
        do_reset();
        update(-100); chk("R6 lower clamp", tune_word, 0);
    endtask

    task automatic t_acc_clamp();
        int bad;
        config_set(0, 7, 0, 0, 0, 0, 1, 0);
        do_reset();
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            update(2047);
            if (tune_word != 16'd65535) bad++;
        end
        chk("R5 positive clamp holds", bad, 0);
        bad = 0;
        for (int k = 1; k <= 80; k++) begin
            update(-2048);
            if (k >= 32 && tune_word != 16'd0) bad++;
        end
        chk("R5 negative clamp holds", bad, 0);
    endtask

    task automatic t_lock_detect();
        config_set(4, 1, 1, 0, 1000, 5, 3, 0);
        do_reset();
        update(2); update(-4); update(5); update(1); update(1);
        chk("R7 count restarted", locked, 0);
        chk("R8 not yet shifted", tracking, 0);
        update(1);
        chk("R7 lock after 3", locked, 1);
        chk("R8 lock shift", tracking, 1);
        update(9);
        chk("R7 excursion clears", locked, 0);
        chk("R11 track hold", tracking, 1);
        update(1); update(-1); update(0);
        chk("R7 relock", locked, 1);
    endtask

    task automatic t_bumpless();
        config_set(4, 2, 1, 0, 1000, 4, 1, 0);
        do_reset();
        update(3); chk("R8 shift update uses acq gains", tune_word, 1060);
        chk("R8 shifted", tracking, 1);
        update(0); chk("R10 no step after shift", tune_word, 1060);
        update(2); chk("R3 R4 tracking gains", tune_word, 1066);
    endtask

    task automatic t_timer();
        config_set(4, 0, 0, 0, 1000, 0, 1, 4);
        do_reset();
        update(1); update(1); update(1);
        chk("R4 acc at update 3", tune_word, 1019);
        chk("R9 before timeout", tracking, 0);
        update(1);
        chk("R9 timeout shift", tracking, 1);
        chk("R9 locked stays low", locked, 0);
        update(1); chk("R10 R3 after timer shift", tune_word, 1022);
        update(0); chk("R10 folded term kept", tune_word, 1021);
    endtask

    task automatic t_reset_midrun();
        center_word = 16'd2000;
        do_reset();
        chk("R1 mid-run tune", tune_word, 2000);
        chk("R1 mid-run tracking", tracking, 0);
        chk("R1 mid-run locked", locked, 0);
    endtask

    initial begin
        t_reset_state();
        t_pi_paths();
        t_idle_hold();
        t_out_clamp();
        t_acc_clamp();
        t_lock_detect();
        t_bumpless();
        t_timer();
        t_reset_midrun();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule